// File: doc/BRIEF.md
# Modular Exponentiation Engine

This block raises a message to an exponent modulo a one-word modulus, producing `msg ^ expo mod modulus`. It is the arithmetic core of a public-key cipher datapath. Encryption feeds it the plaintext and the public exponent. Decryption feeds it the ciphertext and the private exponent. Both use the same engine without change.

A one-cycle `start` pulse while idle captures all three operands. The engine first reduces the message modulo the modulus with a bit-serial reducer. It then skips the zero bits above the highest set exponent bit and seeds the accumulator with the reduced base. For every lower exponent bit, from high to low, it squares the accumulator modulo the modulus. When that bit is one, it also multiplies the square by the reduced base modulo the modulus. For an exponent of 149 (binary 10010101), the accumulator therefore holds the powers 1, 2, 4, 9, 18, 37, 74 and 149 in turn.

Each modular product comes from one shared sequential unit. That unit interleaves a shift-and-add multiplication with a conditional subtraction of the modulus, one multiplier bit per cycle. The double-width product never exists in full. `done` pulses for one cycle when the result is ready, and `result` holds until the next run completes.

Top module: `modexp_engine`

## Requirements
- R1: After reset, `busy` is 0, `done` is 0 and `result` is 0.
- R2: A `start` pulse seen while `busy` is 0 is accepted, and `busy` reads 1 in the following cycle.
- R3: For any `msg` and `expo` below 2^W and any `modulus` of at least 1, the completed `result` equals `msg ^ expo mod modulus`.
- R4: With `expo` equal to 0 and `modulus` greater than 1, the result is 1.
- R5: With `modulus` equal to 1, the result is 0 for every message and exponent.
- R6: A message equal to or larger than the modulus gives the same result as the message reduced modulo the modulus.
- R7: `done` is high for exactly one cycle per accepted start, and `busy` is already 0 in that cycle.
- R8: A `start` pulse or an operand change while `busy` is 1 has no effect on the run in progress or on its result.
- R9: `result` changes only in a cycle where `done` is 1, and otherwise keeps its value.
- R10: Every modular product and the reduced base, and therefore every result, are strictly below the modulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request; sampled only while idle |
| msg | input | W | Message or ciphertext operand |
| expo | input | W | Exponent, public or private |
| modulus | input | W | Modulus; must be at least 1 |
| busy | output | 1 | High while a computation is in progress |
| done | output | 1 | One-cycle pulse when `result` is updated |
| result | output | W | msg ^ expo mod modulus, held until the next completion |

## Verification
The range assertions for the reducer and the multiplier, which hold every value below the modulus, rely on the modulus captured at start being nonzero. A zero modulus has no defined result. The sweeps therefore draw every modulus from a list whose smallest entry is 1. The messages are chosen to cover values above the modulus. The exponents cover zero, one, all-ones and values with long runs of leading zeros. The pulse and hold assertions assume `start` may arrive at any time. The bench exercises this by pulsing `start` and changing operands in the middle of a run.

// File: rtl/modexp_pkg.sv
package modexp_pkg;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_BASE = 3'd1,
        S_SCAN = 3'd2,
        S_SQR  = 3'd3,
        S_MUL  = 3'd4
    } mx_state_t;

endpackage

// File: rtl/modexp_reduce.sv
// Bit-serial reduction of a W-bit value modulo a W-bit modulus, W cycles.
module modexp_reduce #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] n_in,
    output logic         fin,
    output logic [W-1:0] rem
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]  x;
        logic [W-1:0]  n;
        logic [W-1:0]  r;
        logic [CW-1:0] cnt;
        logic          run;
        logic          fin;
    } red_t;

    red_t q, d;

    always_comb begin
        logic [W:0] t;
        d     = q;
        d.fin = 1'b0;
        t     = '0;
        if (go) begin
            d.x   = x_in;
            d.n   = n_in;
            d.r   = '0;
            d.cnt = CW'(W);
            d.run = 1'b1;
        end else if (q.run) begin
            t = {q.r, q.x[W-1]};
            if (t >= {1'b0, q.n}) t = t - {1'b0, q.n};
            d.r   = t[W-1:0];
            d.x   = q.x << 1;
            d.cnt = q.cnt - CW'(1);
            if (q.cnt == CW'(1)) begin
                d.run = 1'b0;
                d.fin = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fin = q.fin;
    assign rem = q.r;

    p_base_below_n_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> (rem < q.n));

    p_fin_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !fin);

endmodule

// File: rtl/modexp_mulmod.sv
// Interleaved shift-add modular multiplier: a*b mod n in W cycles, needs a < n.
module modexp_mulmod #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] n_in,
    output logic         fin,
    output logic [W-1:0] prod
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]  a;
        logic [W-1:0]  b;
        logic [W-1:0]  n;
        logic [W-1:0]  acc;
        logic [CW-1:0] cnt;
        logic          run;
        logic          fin;
    } mm_t;

    mm_t q, d;

    always_comb begin
        logic [W:0] t;
        d     = q;
        d.fin = 1'b0;
        t     = '0;
        if (go) begin
            d.a   = a_in;
            d.b   = b_in;
            d.n   = n_in;
            d.acc = '0;
            d.cnt = CW'(W);
            d.run = 1'b1;
        end else if (q.run) begin
            t = {q.acc, 1'b0};
            if (t >= {1'b0, q.n}) t = t - {1'b0, q.n};
            if (q.b[W-1]) t = t + {1'b0, q.a};
            if (t >= {1'b0, q.n}) t = t - {1'b0, q.n};
            d.acc = t[W-1:0];
            d.b   = q.b << 1;
            d.cnt = q.cnt - CW'(1);
            if (q.cnt == CW'(1)) begin
                d.run = 1'b0;
                d.fin = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fin  = q.fin;
    assign prod = q.acc;

    p_prod_below_n_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> (prod < q.n));

    p_operand_reduced_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q.run |-> (q.a < q.n));

endmodule

// File: rtl/modexp_engine.sv
module modexp_engine
    import modexp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] msg,
    input  logic [W-1:0] expo,
    input  logic [W-1:0] modulus,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        mx_state_t     st;
        logic [W-1:0]  e;
        logic [W-1:0]  n;
        logic [W-1:0]  m;
        logic [W-1:0]  base;
        logic [W-1:0]  op_a;
        logic [W-1:0]  op_b;
        logic [CW-1:0] left;
        logic          kick_red;
        logic          kick_mm;
        logic          done;
        logic [W-1:0]  res;
    } eng_t;

    eng_t q, d;

    logic         rd_fin;
    logic [W-1:0] rd_val;
    logic         mm_fin;
    logic [W-1:0] mm_val;

    modexp_reduce #(.W(W)) u_reduce (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (q.kick_red),
        .x_in  (q.m),
        .n_in  (q.n),
        .fin   (rd_fin),
        .rem   (rd_val)
    );

    modexp_mulmod #(.W(W)) u_mulmod (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (q.kick_mm),
        .a_in  (q.op_a),
        .b_in  (q.op_b),
        .n_in  (q.n),
        .fin   (mm_fin),
        .prod  (mm_val)
    );

    always_comb begin
        logic         adv;
        logic [W-1:0] v;
        d          = q;
        d.kick_red = 1'b0;
        d.kick_mm  = 1'b0;
        d.done     = 1'b0;
        adv        = 1'b0;
        v          = '0;
        unique case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.e        = expo;
                    d.n        = modulus;
                    d.m        = msg;
                    d.left     = CW'(W);
                    d.kick_red = 1'b1;
                    d.st       = S_BASE;
                end
            end
            S_BASE: begin
                if (rd_fin) begin
                    d.base = rd_val;
                    d.st   = S_SCAN;
                end
            end
            S_SCAN: begin
                if (q.e == '0) begin
                    d.res  = {{(W-1){1'b0}}, (q.n != {{(W-1){1'b0}}, 1'b1})};
                    d.done = 1'b1;
                    d.st   = S_IDLE;
                end else if (!q.e[W-1]) begin
                    d.e    = q.e << 1;
                    d.left = q.left - CW'(1);
                end else begin
                    adv = 1'b1;
                    v   = q.base;
                end
            end
            S_SQR: begin
                if (mm_fin) begin
                    if (q.e[W-1]) begin
                        d.op_a    = q.base;
                        d.op_b    = mm_val;
                        d.kick_mm = 1'b1;
                        d.st      = S_MUL;
                    end else begin
                        adv = 1'b1;
                        v   = mm_val;
                    end
                end
            end
            S_MUL: begin
                if (mm_fin) begin
                    adv = 1'b1;
                    v   = mm_val;
                end
            end
            default: d.st = S_IDLE;
        endcase

        if (adv) begin
            d.e    = q.e << 1;
            d.left = q.left - CW'(1);
            if (q.left == CW'(1)) begin
                d.res  = v;
                d.done = 1'b1;
                d.st   = S_IDLE;
            end else begin
                d.op_a    = v;
                d.op_b    = v;
                d.kick_mm = 1'b1;
                d.st      = S_SQR;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy   = (q.st != S_IDLE);
    assign done   = q.done;
    assign result = q.res;

    p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    p_result_below_n_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result < q.n));

    p_modulus_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (q.n != '0));

endmodule

// File: tb/tb_modexp_engine.sv
module tb_modexp_engine;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        st8 = 1'b0;
    logic [7:0]  m8 = '0, e8 = '0, n8 = 8'd1;
    logic        busy8, done8;
    logic [7:0]  res8;

    logic        st32 = 1'b0;
    logic [31:0] m32 = '0, e32 = '0, n32 = 32'd1;
    logic        busy32, done32;
    logic [31:0] res32;

    int checks = 0;
    int failures = 0;

    modexp_engine #(.W(8)) dut (
        .clk(clk), .rst_n(rst_n), .start(st8), .msg(m8), .expo(e8),
        .modulus(n8), .busy(busy8), .done(done8), .result(res8)
    );

    modexp_engine #(.W(32)) dut_w (
        .clk(clk), .rst_n(rst_n), .start(st32), .msg(m32), .expo(e32),
        .modulus(n32), .busy(busy32), .done(done32), .result(res32)
    );

    function automatic logic [63:0] modpow(input logic [63:0] m, input logic [63:0] e,
                                          input logic [63:0] n);
        logic [63:0] r, b, x;
        r = 64'd1 % n;
        b = m % n;
        x = e;
        while (x != 0) begin
            if (x[0]) r = (r * b) % n;
            b = (b * b) % n;
            x = x >> 1;
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run8(input logic [7:0] m, input logic [7:0] e, input logic [7:0] n,
                        input string req);
        int cyc;
        @(negedge clk);
        m8 = m; e8 = e; n8 = n; st8 = 1'b1;
        @(negedge clk);
        st8 = 1'b0;
        cyc = 0;
        while (!done8 && cyc < 4000) begin
            @(negedge clk);
            cyc++;
        end
        chk(done8 === 1'b1, {req, " completion"}, {63'd0, done8}, 64'd1);
        chk(res8 == modpow(m, e, n), req, res8, modpow(m, e, n));
    endtask

    task automatic run32(input logic [31:0] m, input logic [31:0] e, input logic [31:0] n,
                         input string req);
        int cyc;
        @(negedge clk);
        m32 = m; e32 = e; n32 = n; st32 = 1'b1;
        @(negedge clk);
        st32 = 1'b0;
        cyc = 0;
        while (!done32 && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        chk(done32 === 1'b1, {req, " completion"}, {63'd0, done32}, 64'd1);
        chk(res32 == modpow(m, e, n), req, res32, modpow(m, e, n));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] nlist [9];
        logic [7:0] held;
        int cyc;
        nlist = '{8'd1, 8'd2, 8'd3, 8'd5, 8'd7, 8'd13, 8'd128, 8'd251, 8'd255};

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(busy8 == 1'b0 && busy32 == 1'b0, "R1 busy", {63'd0, busy8}, 0);
        chk(done8 == 1'b0 && done32 == 1'b0, "R1 done", {63'd0, done8}, 0);
        chk(res8 == 8'd0 && res32 == 32'd0, "R1 result", res8, 0);
        rst_n = 1'b1;

        // R2: start accepted while idle
        @(negedge clk);
        m8 = 8'd9; e8 = 8'd3; n8 = 8'd11; st8 = 1'b1;
        @(negedge clk);
        st8 = 1'b0;
        chk(busy8 == 1'b1, "R2 busy after start", {63'd0, busy8}, 1);
        cyc = 0;
        while (!done8 && cyc < 4000) begin @(negedge clk); cyc++; end
        // R7: done with busy low, then a single pulse
        chk(done8 == 1'b1 && busy8 == 1'b0, "R7 done while idle", {63'd0, busy8}, 0);
        chk(res8 == 8'd3, "R3 9^3 mod 11", res8, 3);
        @(negedge clk);
        chk(done8 == 1'b0, "R7 done one cycle", {63'd0, done8}, 0);

        // R3, R4, R5, R6: sweep of moduli and exponents, messages above and below n
        for (int ni = 0; ni < 9; ni++) begin
            for (int e = 0; e < 256; e += 7) begin
                logic [7:0] m;
                m = 8'((e * 37 + ni * 53 + 3) & 255);
                if (nlist[ni] == 8'd1)      run8(m, 8'(e), nlist[ni], "R5 modulus one");
                else if (e == 0)            run8(m, 8'(e), nlist[ni], "R4 zero exponent");
                else if (m >= nlist[ni])    run8(m, 8'(e), nlist[ni], "R6 message above modulus");
                else                        run8(m, 8'(e), nlist[ni], "R3 sweep");
            end
        end
        run8(8'd200, 8'd255, 8'd251, "R3 all-ones exponent");
        run8(8'd77, 8'd1, 8'd13, "R6 exponent one");
        run8(8'd255, 8'd0, 8'd2, "R4 zero exponent n=2");
        run8(8'd250, 8'd250, 8'd255, "R10 result below n");
        chk(res8 < 8'd255, "R10 range", res8, 254);

        // R8: start and operand changes while busy are ignored
        @(negedge clk);
        m8 = 8'd200; e8 = 8'd201; n8 = 8'd251; st8 = 1'b1;
        @(negedge clk);
        st8 = 1'b0;
        repeat (20) @(negedge clk);
        m8 = 8'd3; e8 = 8'd5; n8 = 8'd7; st8 = 1'b1;
        @(negedge clk);
        st8 = 1'b0;
        repeat (15) @(negedge clk);
        st8 = 1'b1;
        @(negedge clk);
        st8 = 1'b0;
        cyc = 0;
        while (!done8 && cyc < 4000) begin @(negedge clk); cyc++; end
        chk(res8 == modpow(200, 201, 251), "R8 mid-run start ignored", res8,
            modpow(200, 201, 251));
        held = res8;

        // R9: result held without a new start
        m8 = 8'd4; e8 = 8'd4; n8 = 8'd9;
        repeat (40) @(negedge clk);
        chk(res8 == held && busy8 == 1'b0, "R9 result held", res8, held);
        chk(done8 == 1'b0, "R8 no extra completion", {63'd0, done8}, 0);

        // Full-width instance
        run32(32'd123456789, 32'd149, 32'd4294967291, "R3 wide exponent 149");
        run32(32'hDEADBEEF, 32'd65537, 32'hFFFFFFFB, "R6 wide public exponent");
        run32(32'h12345678, 32'hFFFFFFFF, 32'hFFFFFF2F, "R3 wide all-ones exponent");
        run32(32'hCAFEBABE, 32'd0, 32'd1000003, "R4 wide zero exponent");
        run32(32'hCAFEBABE, 32'h87654321, 32'd1, "R5 wide modulus one");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule